// File: doc/BRIEF.md
# Ternary Correlation Slice Accumulator

This block is one lane of a digital correlator for samples quantised to three levels. Each clock it receives two ternary samples. Each sample is a sign bit and a magnitude bit. A small gate checks whether the product of the two samples equals the correlation term this lane is set to count. Two mode inputs set that term: the autocorrelation of the first sample, or the positive or negated cross product of both samples. Each clock in which the gate reports a match adds one to the count.

The count is kept in two stages. A narrow prescaler counts every match. A wider period counter advances once each time the prescaler wraps, so the lane holds only the upper part of the full match total. A dump strobe from outside ends an integration period. On that strobe the period counter's value goes into a holding buffer, and the period counter restarts from zero. The buffer then stays unchanged until the next strobe, so a slower reader can fetch it at any time. Choosing the sample pair, timing the integration period and reading the buffer over a bus are handled outside this block.

Top module: `corr_slice`

## Requirements
- R1: A sample whose magnitude bit is 0 has the value 0 whatever its sign bit. Magnitude 1 with sign 0 is +1. Magnitude 1 with sign 1 is -1.
- R2: With auto_mode=0 and neg_pol=0, a clock counts as a match when both samples are nonzero and their sign bits are equal (product +1).
- R3: With auto_mode=0 and neg_pol=1, a clock counts as a match when both samples are nonzero and their sign bits differ (product -1).
- R4: With auto_mode=1, sample B is ignored. With neg_pol=0, a clock matches whenever sample A is nonzero. With neg_pol=1, no clock matches, because a square is never -1.
- R5: The PRE_W-bit prescaler advances by one on every matching clock and wraps from its all-ones value to zero. A dump strobe does not clear it, so a partial count carries into the next period.
- R6: The CNT_W-bit period counter advances by one on each prescaler wrap, modulo 2^CNT_W.
- R7: On a clock with dump=1, hold_o takes the period count including any wrap in that same clock, and the period counter restarts at zero.
- R8: On a clock with dump=0, hold_o keeps its value.
- R9: A synchronous reset clears the prescaler, the period counter and the buffer. hold_o reads 0 after the reset clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sign | input | 1 | Sign bit of sample A (1 = negative) |
| a_mag | input | 1 | Magnitude bit of sample A (1 = nonzero) |
| b_sign | input | 1 | Sign bit of sample B |
| b_mag | input | 1 | Magnitude bit of sample B |
| auto_mode | input | 1 | 1 = square of A, 0 = product of A and B |
| neg_pol | input | 1 | 1 = count products of -1, 0 = count products of +1 |
| dump | input | 1 | Ends the period: latch the count, restart the counter |
| hold_o | output | CNT_W | Period count latched at the last dump |

## Verification
The match gate has no register, but its effect is seen only through the registered prescaler and counter. A match or dump applied before a rising edge therefore reaches hold_o one edge later. The bench drives every input at the falling edge and updates its expected state for the coming rising edge. It then compares hold_o at the next falling edge, so each result is read exactly one edge after its stimulus. The sweeps check the buffer after a dump against an arithmetic expectation: the number of matches divided by 2^PRE_W. Boundary runs place a wrap on the dump clock, carry a partial prescaler count across a dump, and reset in the middle of a period.

// File: rtl/corr_slice_pkg.sv
package corr_slice_pkg;

    // Ternary sample: magnitude 0 means zero, otherwise sign selects -1/+1.
    typedef struct packed {
        logic neg;
        logic mag;
    } tern_t;

endpackage

// File: rtl/corr_match_gate.sv
module corr_match_gate
    import corr_slice_pkg::*;
(
    input  tern_t smp_a,
    input  tern_t smp_b,
    input  logic  auto_mode,
    input  logic  neg_pol,
    output logic  match_o
);

    logic nonzero;
    logic signs_agree;

    always_comb begin
        // Autocorrelation squares A: nonzero when A is, sign always agrees.
        nonzero     = smp_a.mag & (auto_mode | smp_b.mag);
        signs_agree = auto_mode | (smp_a.neg == smp_b.neg);
        match_o     = nonzero & (neg_pol ? ~signs_agree : signs_agree);
    end

    // R4: a square can never equal -1
    always_comb begin
        a_r4_auto_neg_silent: assert (!(auto_mode && neg_pol && match_o))
            else $error("negative autocorrelation produced a match");
    end

    // R1: a zero magnitude in any used sample yields no match
    always_comb begin
        a_r1_zero_blocks: assert (!(match_o && !smp_a.mag))
            else $error("match with zero sample A");
    end

endmodule

// File: rtl/corr_prescaler.sv
module corr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    output logic wrap_o
);

    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = inc_i && (st_q.pre == PRE_TOP);
        if (inc_i) begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R5: one step per match
    a_r5_pre_step: assert property (@(posedge clk) disable iff (rst)
        inc_i |=> st_q.pre == $past(st_q.pre) + 1'b1);

    // R5: no match, no movement
    a_r5_pre_idle: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> $stable(st_q.pre));

    // R5: a wrap leaves the prescaler at zero
    a_r5_pre_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> st_q.pre == '0);

endmodule

// File: rtl/corr_period_counter.sv
module corr_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             dump_i,
    output logic [CNT_W-1:0] hold_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } per_state_t;

    per_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d     = st_q;
        cnt_next = st_q.cnt + {{(CNT_W-1){1'b0}}, step_i};
        if (dump_i) begin
            st_d.hold = cnt_next;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = cnt_next;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hold_o = st_q.hold;

    // R6: a wrap outside a dump advances the counter
    a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
        (step_i && !dump_i) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R7: a dump restarts the period
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        dump_i |=> st_q.cnt == '0);

    // R7: a same-clock wrap lands in the buffer
    a_r7_capture_wrap: assert property (@(posedge clk) disable iff (rst)
        (dump_i && step_i) |=> hold_o == $past(st_q.cnt) + 1'b1);

    // R8: buffer steady between dumps
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !dump_i |=> $stable(hold_o));

    // R9: reset empties the buffer and counter
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (hold_o == '0) && (st_q.cnt == '0));

endmodule

// File: rtl/corr_slice.sv
module corr_slice
    import corr_slice_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_sign,
    input  logic             a_mag,
    input  logic             b_sign,
    input  logic             b_mag,
    input  logic             auto_mode,
    input  logic             neg_pol,
    input  logic             dump,
    output logic [CNT_W-1:0] hold_o
);

    tern_t smp_a, smp_b;
    logic  match;
    logic  wrap;

    assign smp_a = '{neg: a_sign, mag: a_mag};
    assign smp_b = '{neg: b_sign, mag: b_mag};

    corr_match_gate u_gate (
        .smp_a     (smp_a),
        .smp_b     (smp_b),
        .auto_mode (auto_mode),
        .neg_pol   (neg_pol),
        .match_o   (match)
    );

    corr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (match),
        .wrap_o (wrap)
    );

    corr_period_counter #(.CNT_W(CNT_W)) u_per (
        .clk    (clk),
        .rst    (rst),
        .step_i (wrap),
        .dump_i (dump),
        .hold_o (hold_o)
    );

    // R4: in autocorrelation mode sample B never creates a wrap alone
    a_r4_auto_needs_a: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && !a_mag) |-> !wrap);

endmodule

// File: tb/corr_slice_bench.sv
`timescale 1ns/1ps
module corr_slice_bench;

    localparam int PRE_W = 8;
    localparam int CNT_W = 16;
    localparam int PRE_MOD = 1 << PRE_W;
    localparam int CNT_MOD = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_sign = 0, a_mag = 0, b_sign = 0, b_mag = 0;
    logic auto_mode = 0, neg_pol = 0, dump = 0;
    logic [CNT_W-1:0] hold_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_pre = 0, m_cnt = 0, m_hold = 0;

    always #2.5 clk = ~clk;

    corr_slice #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_corr_slice (
        .clk(clk), .rst(rst), .a_sign(a_sign), .a_mag(a_mag),
        .b_sign(b_sign), .b_mag(b_mag), .auto_mode(auto_mode),
        .neg_pol(neg_pol), .dump(dump), .hold_o(hold_o)
    );

    function automatic int tern_val(input logic s, input logic m);
        return m ? (s ? -1 : 1) : 0;   // R1 encoding
    endfunction

    function automatic bit exp_match();
        int va, vb, prod;
        va = tern_val(a_sign, a_mag);
        vb = tern_val(b_sign, b_mag);
        prod = auto_mode ? va * va : va * vb;
        return neg_pol ? (prod == -1) : (prod == 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: hold_o=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs are already set; apply dump for one clock, check next falling edge.
    task automatic tick(input bit dmp, input string req);
        bit em, carry;
        dump  = dmp;
        em    = exp_match();
        carry = em && (m_pre == PRE_MOD - 1);
        m_pre = (m_pre + int'(em)) % PRE_MOD;
        if (dmp) begin
            m_hold = (m_cnt + int'(carry)) % CNT_MOD;
            m_cnt  = 0;
        end else begin
            m_cnt = (m_cnt + int'(carry)) % CNT_MOD;
        end
        @(posedge clk);
        @(negedge clk);
        check(req, int'(hold_o), m_hold);
        dump = 0;
    endtask

    task automatic do_reset();
        rst  = 1;
        dump = 0;
        @(posedge clk);
        @(negedge clk);
        check("R9", int'(hold_o), 0);
        rst = 0;
        m_pre = 0; m_cnt = 0; m_hold = 0;
    endtask

    task automatic set_pos_match();
        auto_mode = 0; neg_pol = 0;
        a_sign = 0; a_mag = 1; b_sign = 0; b_mag = 1;
    endtask

    task automatic set_idle();
        a_mag = 0; b_mag = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Sweep R1-style encodings over all modes: R2, R3, R4
        for (int md = 0; md < 4; md++) begin
            for (int ia = 0; ia < 4; ia++) begin
                for (int ib = 0; ib < 4; ib++) begin
                    int exp_hold;
                    string req;
                    do_reset();
                    auto_mode = md[1];
                    neg_pol   = md[0];
                    a_sign = ia[1]; a_mag = ia[0];
                    b_sign = ib[1]; b_mag = ib[0];
                    req = auto_mode ? "R4" : (neg_pol ? "R3" : "R2");
                    exp_hold = (int'(exp_match()) * 301) / PRE_MOD;
                    for (int k = 0; k < 300; k++) tick(0, "R8");
                    tick(1, "R7");
                    check(req, int'(hold_o), exp_hold);
                    // R1: sign with zero magnitude counts as zero
                    if (ia == 2 || (ib == 2 && !auto_mode)) check("R1", int'(hold_o), 0);
                end
            end
        end

        // R7: wrap on the dump clock goes into the buffer
        do_reset();
        set_pos_match();
        for (int k = 0; k < PRE_MOD - 1; k++) tick(0, "R8");
        tick(1, "R7");
        check("R7", int'(hold_o), 1);
        // R6/R7: counter restarted; one more full wrap then dump idle
        for (int k = 0; k < PRE_MOD; k++) tick(0, "R8");
        set_idle();
        tick(1, "R7");
        check("R6", int'(hold_o), 1);

        // R5: partial prescaler count carries across a dump
        do_reset();
        set_pos_match();
        for (int k = 0; k < 200; k++) tick(0, "R8");
        set_idle();
        tick(1, "R7");
        check("R5", int'(hold_o), 0);
        set_pos_match();
        for (int k = 0; k < PRE_MOD - 200; k++) tick(0, "R8");
        set_idle();
        tick(1, "R7");
        check("R5", int'(hold_o), 1);

        // R6: several wraps accumulate
        do_reset();
        set_pos_match();
        for (int k = 0; k < 5 * PRE_MOD + 17; k++) tick(0, "R8");
        set_idle();
        tick(1, "R7");
        check("R6", int'(hold_o), 5);
        // R8: buffer steady while counting resumes without dump
        set_pos_match();
        for (int k = 0; k < 2 * PRE_MOD; k++) tick(0, "R8");
        check("R8", int'(hold_o), 5);

        // R9: mid-period reset clears prescaler too
        do_reset();
        check("R9", int'(hold_o), 0);
        set_pos_match();
        for (int k = 0; k < PRE_MOD - 1; k++) tick(0, "R8");
        set_idle();
        tick(1, "R9");
        check("R9", int'(hold_o), 0);
        set_pos_match();
        tick(0, "R8");
        set_idle();
        tick(1, "R5");
        check("R5", int'(hold_o), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule